// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor

This block drives an active-low system reset from two digitized supply-monitor flags and a service input from a processor. It holds reset low while the supply is out of regulation. Once the supply has recovered, it waits a power-on delay and then releases reset. From that point it expects a qualified falling edge on the service input within every watchdog window. When a window passes with no such edge, it drives a free-running reset square wave. The wave ends as soon as a qualified edge is seen.

The supply flags are treated as synchronous digital inputs. Supply hysteresis is kept in a one-bit regulated flag. The flag is set only by the above-high flag and cleared only by the below-low flag. The service input is asynchronous: it passes through a two-flop synchronizer whose reset value is high, so an undriven input behaves like a missing service.

The power-on delay and the watchdog window both default to one shared timing base. One counter times both. The control state machine has five states:

| State | Meaning |
|---|---|
| `ST_SUPPLY_LOST` | Supply not regulated; reset is held low. |
| `ST_POR_DELAY` | Supply regulated; the power-on delay is running; reset stays low. |
| `ST_WATCH` | Reset is released; the watchdog window is running. |
| `ST_PULSE_LO` | Low half of the reset square wave. |
| `ST_PULSE_HI` | High half of the reset square wave. |

The transitions are:

| From | To | Condition |
|---|---|---|
| any state | `ST_SUPPLY_LOST` | The regulated flag is clear. |
| `ST_SUPPLY_LOST` | `ST_POR_DELAY` | The regulated flag is set. |
| `ST_POR_DELAY` | `ST_WATCH` | The delay count completes. |
| `ST_WATCH` | `ST_WATCH` (count restarted) | A service event arrives. |
| `ST_WATCH` | `ST_PULSE_LO` | The window expires. |
| `ST_PULSE_LO` | `ST_PULSE_HI` | The half period expires. |
| `ST_PULSE_HI` | `ST_PULSE_LO` | The half period expires. |
| `ST_PULSE_LO` or `ST_PULSE_HI` | `ST_WATCH` | A service event arrives. |

Top module: `por_wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, and afterwards until the power-on delay has completed, `sys_rst_n` is 0.
- R2: The supply counts as regulated only after `sup_above_hi` is sampled 1. It counts as lost only after `sup_below_lo` is sampled 1. When both flags are 0, the previous condition is kept. When both flags are 1, the supply counts as lost.
- R3: When the supply becomes regulated, `sys_rst_n` rises exactly POR_CYCLES+1 clock edges after the first edge that samples `sup_above_hi` as 1.
- R4: When `sup_below_lo` is sampled 1 at edge k, `sys_rst_n` is 0 from edge k+1 onward. The power-on delay then starts again from zero.
- R5: A service event is a run of at least MIN_LOW consecutive samples of 0 on `wdog_in`. Each such run counts once. The event takes effect at the edge MIN_LOW+1 edges after the first low sample. A run shorter than MIN_LOW samples has no effect.
- R6: Rising edges and steady levels on `wdog_in`, whether held high (as when floating) or held low, are not service events.
- R7: After reset is released, or after a service event in the window, `sys_rst_n` stays 1 for exactly WD_CYCLES edges. If no service event arrives in that time, it then falls to 0.
- R8: After a missed window, `sys_rst_n` alternates between 0 and 1. Each level lasts exactly WD_CYCLES edges, so the duty cycle is 50%.
- R9: A service event during the square wave sets `sys_rst_n` to 1 at the edge where the event takes effect, and a new window starts at that edge.
- R10: Activity on `wdog_in` while reset is held for supply loss or for the power-on delay changes neither the release time nor the first window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor itself |
| sup_below_lo | input | 1 | Supply is below the low threshold |
| sup_above_hi | input | 1 | Supply is above the high threshold |
| wdog_in | input | 1 | Asynchronous watchdog service input; a qualified falling edge services the watchdog |
| sys_rst_n | output | 1 | Active-low system reset output |

## Verification
The bench builds the block with TBASE_CYCLES = 40, which sets both the power-on delay and the watchdog window to 40 cycles, and with MIN_LOW = 4. These values keep several full square-wave periods, repeated power-on sequences and window restarts within a few thousand cycles. That short run still lets the bench check every release and expiry at the exact edge. With MIN_LOW = 4, a three-sample low run and a four-sample low run fall on either side of the qualification threshold.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [2:0] {
        ST_SUPPLY_LOST = 3'd0,
        ST_POR_DELAY   = 3'd1,
        ST_WATCH       = 3'd2,
        ST_PULSE_LO    = 3'd3,
        ST_PULSE_HI    = 3'd4
    } sup_state_e;

    // Reset output level associated with a state.
    function automatic logic state_releases(sup_state_e s);
        return (s == ST_WATCH) || (s == ST_PULSE_HI);
    endfunction

endpackage

// File: rtl/rsup_sync2.sv
module rsup_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RESET_VAL;
            q_sync <= RESET_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

endmodule

// File: rtl/rsup_svc_qual.sv
// Turns a synchronized service level into a single-cycle event once the
// level has been low for MIN_LOW consecutive samples.
module rsup_svc_qual #(
    parameter int MIN_LOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic svc_s,
    output logic svc_evt
);

    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] RUN_FULL = LW'(MIN_LOW);
    localparam logic [LW-1:0] RUN_LAST = LW'(MIN_LOW - 1);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (svc_s) begin
            low_run <= '0;
        end else if (low_run != RUN_FULL) begin
            low_run <= low_run + LW'(1);
        end
    end

    assign svc_evt = !svc_s && (low_run == RUN_LAST);

    // R5: one event per low run
    p_single_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_evt |=> !svc_evt);

    // R6: a high level never yields an event
    p_high_no_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_s |-> !svc_evt);

endmodule

// File: rtl/rsup_supply_hyst.sv
module rsup_supply_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic below_lo,
    input  logic above_hi,
    output logic supply_ok
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            supply_ok <= 1'b0;
        end else if (below_lo) begin
            supply_ok <= 1'b0;
        end else if (above_hi) begin
            supply_ok <= 1'b1;
        end
    end

    // R2: inside the hysteresis band the condition is kept
    p_band_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!below_lo && !above_hi) |=> $stable(supply_ok));

    // R2: below-low wins over above-high
    p_low_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        below_lo |=> !supply_ok);

endmodule

// File: rtl/por_wdog_supervisor.sv
module por_wdog_supervisor #(
    parameter int TBASE_CYCLES = 100000,
    parameter int POR_CYCLES   = TBASE_CYCLES,
    parameter int WD_CYCLES    = TBASE_CYCLES,
    parameter int MIN_LOW      = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_below_lo,
    input  logic sup_above_hi,
    input  logic wdog_in,
    output logic sys_rst_n
);
    import rsup_pkg::*;

    localparam int CNT_MAX = (POR_CYCLES > WD_CYCLES) ? POR_CYCLES : WD_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] WD_LAST  = CNT_W'(WD_CYCLES - 1);

    logic             svc_s;
    logic             svc_evt;
    logic             supply_ok;
    sup_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             win_restart;

    rsup_sync2 #(.RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (wdog_in),
        .q_sync  (svc_s)
    );

    rsup_svc_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .svc_s   (svc_s),
        .svc_evt (svc_evt)
    );

    rsup_supply_hyst u_hyst (
        .clk       (clk),
        .rst_n     (rst_n),
        .below_lo  (sup_below_lo),
        .above_hi  (sup_above_hi),
        .supply_ok (supply_ok)
    );

    // Next-state and counter decision
    always_comb begin
        state_nxt   = state;
        win_restart = 1'b0;
        if (!supply_ok) begin
            state_nxt = ST_SUPPLY_LOST;
        end else begin
            unique case (state)
                ST_SUPPLY_LOST: state_nxt = ST_POR_DELAY;
                ST_POR_DELAY: begin
                    if (cnt == POR_LAST) state_nxt = ST_WATCH;
                end
                ST_WATCH: begin
                    if (svc_evt)              win_restart = 1'b1;
                    else if (cnt == WD_LAST)  state_nxt   = ST_PULSE_LO;
                end
                ST_PULSE_LO: begin
                    if (svc_evt)              state_nxt = ST_WATCH;
                    else if (cnt == WD_LAST)  state_nxt = ST_PULSE_HI;
                end
                ST_PULSE_HI: begin
                    if (svc_evt)              state_nxt = ST_WATCH;
                    else if (cnt == WD_LAST)  state_nxt = ST_PULSE_LO;
                end
                default: state_nxt = ST_SUPPLY_LOST;
            endcase
        end

        if ((state_nxt != state) || win_restart || (state == ST_SUPPLY_LOST))
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + CNT_W'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SUPPLY_LOST;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_rst_n <= 1'b0;
        else        sys_rst_n <= state_releases(state_nxt);
    end

    // R4: loss of supply forces reset on the next edge
    p_loss_forces_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !sys_rst_n);

    // R10 / R1: no release while the power-on delay is still counting
    p_por_holds_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POR_DELAY && cnt != POR_LAST) |=> !sys_rst_n);

    // R7: an unserviced window ends with reset low
    p_window_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && supply_ok && !svc_evt && cnt == WD_LAST) |=> !sys_rst_n);

    // R8: high half of the wave ends with reset low
    p_wave_hi_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE_HI && supply_ok && !svc_evt && cnt == WD_LAST) |=> !sys_rst_n);

    // R9: a service event during the wave releases reset
    p_wave_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PULSE_LO || state == ST_PULSE_HI) && supply_ok && svc_evt)
        |=> (sys_rst_n && state == ST_WATCH));

    // Counter stays inside the longest interval
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(CNT_MAX));

endmodule

// File: tb/por_wdog_supervisor_bench.sv
module por_wdog_supervisor_bench;

    localparam int TB  = 40;
    localparam int POR = TB;
    localparam int WD  = TB;
    localparam int ML  = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic sup_below_lo;
    logic sup_above_hi;
    logic wdog_in;
    logic sys_rst_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    por_wdog_supervisor #(
        .TBASE_CYCLES(TB),
        .MIN_LOW(ML)
    ) u_por_wdog_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .sup_below_lo (sup_below_lo),
        .sup_above_hi (sup_above_hi),
        .wdog_in      (wdog_in),
        .sys_rst_n    (sys_rst_n)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic exp);
        checks++;
        if (sys_rst_n !== exp) begin
            errors++;
            $display("FAIL %s: sys_rst_n=%0b expected %0b at %0t", req, sys_rst_n, exp, $time);
        end
    endtask

    // Low pulse on the service input of n samples; returns to high after
    task automatic svc_pulse(input int n);
        wdog_in = 1'b0;
        step(n);
        wdog_in = 1'b1;
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0; sup_below_lo = 1'b1; sup_above_hi = 1'b0; wdog_in = 1'b1;
        step(3);
        chk("R1 under reset", 1'b0);
        rst_n = 1'b1;
        step(5);
        chk("R1 supply still low", 1'b0);
    endtask

    // Bring supply up and check exact release (R3)
    task automatic t_power_up(input string tag);
        sup_below_lo = 1'b0; sup_above_hi = 1'b1;
        step(POR + 1);
        chk({tag, " R3 before release"}, 1'b0);
        step(1);
        chk({tag, " R3 release edge"}, 1'b1);
    endtask

    // From a release edge with the input high: window expires (R6, R7)
    task automatic t_window_expiry(input string tag);
        step(WD - 1);
        chk({tag, " R7 window last high"}, 1'b1);
        step(1);
        chk({tag, " R7 window expired"}, 1'b0);
    endtask

    // From the start of a low half: one full wave period (R8)
    task automatic t_wave_period;
        step(WD - 1);
        chk("R8 low half last", 1'b0);
        step(1);
        chk("R8 high half start", 1'b1);
        step(WD - 1);
        chk("R8 high half last", 1'b1);
        step(1);
        chk("R8 next low half", 1'b0);
    endtask

    // At start of a low half: service stops the wave, then held low = no service
    task automatic t_wave_stop_and_static_low;
        wdog_in = 1'b0;
        step(ML + 1);
        chk("R9 before event", 1'b0);
        step(1);
        chk("R9 wave stopped", 1'b1);
        // input held low: no new event (R6)
        step(WD - 1);
        chk("R6 static low window high", 1'b1);
        step(1);
        chk("R6 static low expires", 1'b0);
        // rising edge alone is no event (R6)
        wdog_in = 1'b1;
        step(WD - 1);
        chk("R6 rising edge ignored", 1'b0);
        step(1);
        chk("R6 wave continues", 1'b1);
    endtask

    // At start of a high half: short pulse ignored, minimum pulse accepted (R5),
    // mid-window service restarts the window (R7)
    task automatic t_qualification;
        svc_pulse(ML - 1);
        step(WD - ML);
        chk("R5 short pulse ignored (high)", 1'b1);
        step(1);
        chk("R5 short pulse ignored (low)", 1'b0);
        step(2);
        wdog_in = 1'b0;
        step(ML);
        wdog_in = 1'b1;
        step(1);
        chk("R5 minimum pulse pending", 1'b0);
        step(1);
        chk("R5 minimum pulse accepted", 1'b1);
        step(20);
        wdog_in = 1'b0;
        step(ML + 2);
        wdog_in = 1'b1;
        chk("R7 still in window", 1'b1);
        step(WD - 1);
        chk("R7 window restarted", 1'b1);
        step(1);
        chk("R7 restarted window expires", 1'b0);
    endtask

    // From start of a low half: service, then supply loss and hysteresis (R2, R4, R10)
    task automatic t_supply_loss;
        svc_pulse(ML + 2);
        chk("R9 released for loss test", 1'b1);
        sup_below_lo = 1'b0; sup_above_hi = 1'b0;
        step(10);
        chk("R2 in-band keeps regulated", 1'b1);
        sup_below_lo = 1'b1; sup_above_hi = 1'b1;
        step(1);
        chk("R4 one edge after loss", 1'b1);
        step(1);
        chk("R4 reset after loss", 1'b0);
        sup_below_lo = 1'b0; sup_above_hi = 1'b0;
        svc_pulse(ML + 2);
        step(3 * POR);
        chk("R2 in-band keeps lost", 1'b0);
        chk("R10 service ignored while lost", 1'b0);
        // power up again with service activity during the delay
        sup_above_hi = 1'b1;
        step(5);
        svc_pulse(ML + 2);
        step(POR + 1 - 5 - (ML + 2));
        chk("R10 before release", 1'b0);
        step(1);
        chk("R10 release unchanged", 1'b1);
        t_window_expiry("R10 first window");
    endtask

    initial begin
        t_reset_state();
        t_power_up("initial");
        t_window_expiry("floating");
        t_wave_period();
        t_wave_stop_and_static_low();
        t_qualification();
        t_supply_loss();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule